// File: doc/BRIEF.md
# Parity-Checked Reversible Gate Library

This block is a purely combinational library of six three-line reversible gates, plus a pass-through setting. A select code picks one gate, and that gate maps the three input lines A, B and C onto the output lines P, Q and R. Three of the gates keep the XOR of their lines unchanged between input and output. These are the double-controlled-NOT, the controlled swap and the fault-tolerant universal gate. The other three are there so the two groups can be compared: the double-controlled AND-XOR, the AND-XOR followed by a controlled-NOT, and the inverted-operand variant of that second gate.

Alongside the mapped lines, the block reports three parity signals:
- the parity of the input lines,
- the parity of the output lines,
- a mismatch flag.

On a parity-preserving gate, the mismatch flag marks any single corrupted output line. A fault-injection field can invert one chosen output line before the parity is taken, so the checker can be tested in place. A constant cost output gives the quantum cost of the selected gate.

Top module: `revgate_lib`

## Requirements
- R1: With `gate_sel` = 0 and no fault, the outputs are P=A, Q=A^B, R=A^C. Line order is `in_vec[0]`=A, `in_vec[1]`=B, `in_vec[2]`=C and `out_vec[0]`=P, `out_vec[1]`=Q, `out_vec[2]`=R.
- R2: With `gate_sel` = 1 and no fault, P=A. B and C pass straight through when A=0 and are swapped when A=1.
- R3: With `gate_sel` = 2 and no fault, P=A^B, Q=(~B&C)^(A&~C), R=(B&C)^(A&~C).
- R4: With no fault, each of the other three gates gives P=A, and their R lines are as follows.
  - `gate_sel` = 3 gives Q=B, R=(A&B)^C.
  - `gate_sel` = 4 gives Q=A^B, R=(A&B)^C.
  - `gate_sel` = 5 gives Q=A^B, R=(A&~B)^C.
- R5: With `gate_sel` = 6 or 7 and no fault, `out_vec` equals `in_vec`.
- R6: For every `gate_sel` value with no fault, the 8 input vectors give 8 distinct output vectors.
- R7: `par_in` is the XOR of the three input lines. `par_out` is the XOR of the three output lines as they appear on `out_vec`, after any injected fault.
- R8: `parity_err` equals `par_in ^ par_out`. With no fault it is 0 for `gate_sel` values 0, 1, 2, 6 and 7, for every input.
- R9: A `fault_sel` value k in 1..3 inverts `out_vec[k-1]`, and 0 injects nothing. On a parity-preserving selection (0, 1, 2, 6, 7), any nonzero `fault_sel` drives `parity_err` to 1.
- R10: `qcost` gives the cost of the selected gate: 2, 5, 5, 5, 4, 6 for `gate_sel` 0 to 5, and 0 for 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_vec | input | 3 | Input lines, bit 0 = A, bit 1 = B, bit 2 = C |
| gate_sel | input | 3 | Gate select code, 0..7 |
| fault_sel | input | 2 | Fault injection: 0 none, k inverts output bit k-1 |
| out_vec | output | 3 | Output lines after fault injection, bit 0 = P |
| par_in | output | 1 | XOR of the input lines |
| par_out | output | 1 | XOR of the output lines |
| parity_err | output | 1 | Parity mismatch flag |
| qcost | output | 3 | Quantum cost of the selected gate |

## Verification
The block holds no state, so a wrong mapping term or a mis-routed mux leg shows at the ports as soon as the inputs settle. It appears as a wrong line on `out_vec`, or as two inputs that collapse onto the same output. A fault routed to the wrong line is caught by direct comparison with the expected vector. A parity stage that ignores the injected fault leaves `parity_err` low while a line is visibly flipped. Sweeping every select code, input and fault value exposes each of these within one settle time.

// File: rtl/revgate_pkg.sv
package revgate_pkg;

   localparam int unsigned LINES   = 3;
   localparam int unsigned SEL_W   = 3;
   localparam int unsigned NCODES  = 1 << SEL_W;
   localparam int unsigned COST_W  = 3;

   typedef enum logic [SEL_W-1:0] {
      G_DFEYN  = 3'd0,
      G_CSWAP  = 3'd1,
      G_FTU    = 3'd2,
      G_TOFF   = 3'd3,
      G_PERES  = 3'd4,
      G_TRG    = 3'd5,
      G_THRU6  = 3'd6,
      G_THRU7  = 3'd7
   } gate_code_t;

   // Mapping of one gate; v[0]=A, v[1]=B, v[2]=C; result[0]=P
   function automatic logic [LINES-1:0] gate_map(input logic [SEL_W-1:0] code,
                                                 input logic [LINES-1:0] v);
      logic a, b, c;
      logic [LINES-1:0] r;
      a = v[0];
      b = v[1];
      c = v[2];
      unique case (gate_code_t'(code))
         G_DFEYN: r = {a ^ c, a ^ b, a};
         G_CSWAP: r = {(~a & c) ^ (a & b), (~a & b) ^ (a & c), a};
         G_FTU:   r = {(b & c) ^ (a & ~c), (~b & c) ^ (a & ~c), a ^ b};
         G_TOFF:  r = {(a & b) ^ c, b, a};
         G_PERES: r = {(a & b) ^ c, a ^ b, a};
         G_TRG:   r = {(a & ~b) ^ c, a ^ b, a};
         default: r = v;
      endcase
      return r;
   endfunction

   function automatic logic [COST_W-1:0] gate_cost(input logic [SEL_W-1:0] code);
      logic [COST_W-1:0] k;
      unique case (gate_code_t'(code))
         G_DFEYN: k = 3'd2;
         G_CSWAP: k = 3'd5;
         G_FTU:   k = 3'd5;
         G_TOFF:  k = 3'd5;
         G_PERES: k = 3'd4;
         G_TRG:   k = 3'd6;
         default: k = 3'd0;
      endcase
      return k;
   endfunction

   function automatic logic keeps_parity(input logic [SEL_W-1:0] code);
      return (code <= 3'd2) || (code >= 3'd6);
   endfunction

endpackage

// File: rtl/revgate_core.sv
module revgate_core
   import revgate_pkg::*;
#(
   parameter int unsigned N_LINES = LINES,
   parameter int unsigned S_W     = SEL_W
) (
   input  logic [N_LINES-1:0] vin,
   input  logic [S_W-1:0]     sel,
   output logic [N_LINES-1:0] vout
);
   localparam int unsigned NLEGS = 1 << S_W;

   if (N_LINES != LINES) begin : g_bad_lines
      $error("revgate_core: gates are defined on exactly three lines");
   end
   if (S_W != SEL_W) begin : g_bad_sel
      $error("revgate_core: select width must match the package");
   end

   logic [N_LINES-1:0] leg [NLEGS];

   for (genvar g = 0; g < NLEGS; g++) begin : g_leg
      localparam logic [S_W-1:0] CODE = S_W'(g);
      assign leg[g] = gate_map(CODE, vin);
   end

   assign vout = leg[sel];
endmodule

// File: rtl/revgate_fault.sv
module revgate_fault #(
   parameter int unsigned N_LINES = 3,
   parameter int unsigned F_W     = 2
) (
   input  logic [N_LINES-1:0] vin,
   input  logic [F_W-1:0]     fsel,
   output logic [N_LINES-1:0] vout
);
   if ((1 << F_W) < N_LINES + 1) begin : g_bad_fw
      $error("revgate_fault: fault field too narrow for line count");
   end

   logic [N_LINES-1:0] flip;

   for (genvar i = 0; i < N_LINES; i++) begin : g_flip
      assign flip[i] = (fsel == F_W'(i + 1));
   end

   assign vout = vin ^ flip;
endmodule

// File: rtl/revgate_parity.sv
module revgate_parity #(
   parameter int unsigned N_LINES = 3
) (
   input  logic [N_LINES-1:0] vin,
   input  logic [N_LINES-1:0] vout,
   output logic               p_in,
   output logic               p_out,
   output logic               p_err
);
   if (N_LINES < 1) begin : g_bad_n
      $error("revgate_parity: need at least one line");
   end

   assign p_in  = ^vin;
   assign p_out = ^vout;
   assign p_err = p_in ^ p_out;
endmodule

// File: rtl/revgate_lib.sv
module revgate_lib
   import revgate_pkg::*;
#(
   parameter int unsigned FAULT_W = 2
) (
   input  logic [2:0]         in_vec,
   input  logic [2:0]         gate_sel,
   input  logic [FAULT_W-1:0] fault_sel,
   output logic [2:0]         out_vec,
   output logic               par_in,
   output logic               par_out,
   output logic               parity_err,
   output logic [2:0]         qcost
);
   logic [LINES-1:0] mapped;

   revgate_core #(.N_LINES(LINES), .S_W(SEL_W)) u_core (
      .vin  (in_vec),
      .sel  (gate_sel),
      .vout (mapped)
   );

   revgate_fault #(.N_LINES(LINES), .F_W(FAULT_W)) u_fault (
      .vin  (mapped),
      .fsel (fault_sel),
      .vout (out_vec)
   );

   revgate_parity #(.N_LINES(LINES)) u_par (
      .vin   (in_vec),
      .vout  (out_vec),
      .p_in  (par_in),
      .p_out (par_out),
      .p_err (parity_err)
   );

   assign qcost = gate_cost(gate_sel);
endmodule

// File: rtl/revgate_lib_chk.sv
module revgate_lib_chk #(
   parameter int unsigned FAULT_W = 2
) (
   input logic [2:0]         in_vec,
   input logic [2:0]         gate_sel,
   input logic [FAULT_W-1:0] fault_sel,
   input logic [2:0]         out_vec,
   input logic               par_in,
   input logic               par_out,
   input logic               parity_err
);
   logic keeps;
   assign keeps = (gate_sel <= 3'd2) || (gate_sel >= 3'd6);

   always_comb begin
      AST_ERR_MATCHES_FLAGS: assert (parity_err == (par_in ^ par_out)) else $error("err flag mismatch"); // R8
      AST_OUT_PARITY_SEEN: assert (par_out == ^out_vec) else $error("par_out mismatch"); // R7
      if (fault_sel == '0 && keeps)
         AST_CLEAN_NO_ERR: assert (!parity_err) else $error("spurious parity error"); // R8
      if (fault_sel != '0 && keeps)
         AST_FAULT_FLAGGED: assert (parity_err) else $error("fault not flagged"); // R9
      if (fault_sel == '0 && gate_sel >= 3'd6)
         AST_THRU_EQUAL: assert (out_vec == in_vec) else $error("pass-through altered"); // R5
      if (fault_sel == '0 && gate_sel == 3'd0)
         AST_DFEYN_CTRL: assert (out_vec[0] == in_vec[0]) else $error("control line altered"); // R1
   end
endmodule

bind revgate_lib revgate_lib_chk #(.FAULT_W(FAULT_W)) u_chk (
   .in_vec     (in_vec),
   .gate_sel   (gate_sel),
   .fault_sel  (fault_sel),
   .out_vec    (out_vec),
   .par_in     (par_in),
   .par_out    (par_out),
   .parity_err (parity_err)
);

// File: tb/revgate_lib_tb.sv
module revgate_lib_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [2:0] in_vec, gate_sel, out_vec, qcost;
   logic [1:0] fault_sel;
   logic par_in, par_out, parity_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   revgate_lib u_dut (
      .in_vec(in_vec), .gate_sel(gate_sel), .fault_sel(fault_sel),
      .out_vec(out_vec), .par_in(par_in), .par_out(par_out),
      .parity_err(parity_err), .qcost(qcost)
   );

   function automatic logic [2:0] ref_map(input int s, input logic [2:0] v);
      logic a, b, c;
      a = v[0]; b = v[1]; c = v[2];
      case (s)
         0: return {a ^ c, a ^ b, a};
         1: return a ? {b, c, a} : v;
         2: return {(b & c) ^ (a & ~c), (~b & c) ^ (a & ~c), a ^ b};
         3: return {(a & b) ^ c, b, a};
         4: return {(a & b) ^ c, a ^ b, a};
         5: return {(a & ~b) ^ c, a ^ b, a};
         default: return v;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply(input int s, input int v, input int f);
      @(negedge clk);
      gate_sel = 3'(s); in_vec = 3'(v); fault_sel = 2'(f);
      #1;
   endtask

   // R1 R2 R3 R4 R5: mappings with no fault
   task automatic t_mappings();
      for (int s = 0; s < 8; s++)
         for (int v = 0; v < 8; v++) begin
            logic [2:0] e;
            apply(s, v, 0);
            e = ref_map(s, 3'(v));
            check(out_vec == e,
                  s == 0 ? "R1" : s == 1 ? "R2" : s == 2 ? "R3" : s <= 5 ? "R4" : "R5",
                  out_vec, e);
         end
   endtask

   // R6: bijection per select code
   task automatic t_bijective();
      for (int s = 0; s < 8; s++) begin
         logic [7:0] seen = '0;
         for (int v = 0; v < 8; v++) begin
            apply(s, v, 0);
            seen[out_vec] = 1'b1;
         end
         check(seen == 8'hFF, "R6", seen, 8'hFF);
      end
   endtask

   // R7 R8 R9: fault injection and parity flags
   task automatic t_faults();
      for (int s = 0; s < 8; s++)
         for (int v = 0; v < 8; v++)
            for (int f = 0; f < 4; f++) begin
               logic [2:0] e;
               logic pe;
               e = ref_map(s, 3'(v));
               if (f != 0) e[f-1] = ~e[f-1];
               apply(s, v, f);
               check(out_vec == e, "R9", out_vec, e);
               check(par_in == ^3'(v) && par_out == ^e, "R7",
                     {par_in, par_out}, {^3'(v), ^e});
               pe = (^3'(v)) ^ (^e);
               check(parity_err == pe, "R8", parity_err, pe);
               if (s <= 2 || s >= 6)
                  check(parity_err == (f != 0), "R9", parity_err, (f != 0));
            end
   endtask

   // R10: cost constants
   task automatic t_cost();
      int exp_cost [8] = '{2, 5, 5, 5, 4, 6, 0, 0};
      for (int s = 0; s < 8; s++) begin
         apply(s, 3, 0);
         check(qcost == 3'(exp_cost[s]), "R10", qcost, exp_cost[s]);
      end
   endtask

   initial begin
      in_vec = '0; gate_sel = '0; fault_sel = '0;
      #1;
      check(out_vec == 3'd0 && parity_err == 1'b0, "R1", out_vec, 0);
      t_mappings();
      t_bijective();
      t_faults();
      t_cost();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule